// File: doc/BRIEF.md
# Row Scanner With Throttled FIFO

This block is one lane of a pixel search stage. It walks across one row of a binary image, one column per clock. Each time it lands on a set pixel, it queues that pixel's column index in a small first-in first-out store. A separate read strobe drains the store at a slower rate. Every accepted read places the oldest queued column on the location output and the stored status bit on the lookup-enable output, ready for a downstream lookup stage.

Scanning can produce entries faster than the strobe drains them. To keep the store from overrunning, an occupancy tally drives a throttle. When the tally reaches the high-water level, scanning and queueing stop for a fixed hold window. That window is re-armed every cycle the tally stays at the high-water level, and it runs out a fixed number of cycles after the tally last sat there. The whole lane works on one clock, and the read strobe is a single-cycle qualifier.

Top module: `rowscan_lane`

## Requirements
- R1: While enable is high and the throttle is off, the scan column advances by one each clock and wraps from COLS-1 (7) to 0. Column k of `rowBits` is examined while the scan column equals k.
- R2: When the examined column holds a 1 and queueing is allowed, one entry is queued: bits [2:0] hold the column index and bit 3, the status bit, is 1. A 0 pixel queues nothing.
- R3: While the throttle is on, nothing is queued and the scan column holds its value.
- R4: Entries leave in the order they were queued, and the store holds up to DEPTH (16) of them. A read sets `location` to the stored column index and `lookupEn` to the stored status bit, and both become visible in the cycle after the strobe.
- R5: The occupancy tally rises by 1 on a queue, falls by 1 on a read, and is unchanged when both or neither happen. It never exceeds AF_LEVEL (14).
- R6: The throttle turns on in the cycle after the occupancy becomes AF_LEVEL. It stays on through HOLD (9) cycles counted from the last cycle that left the occupancy at AF_LEVEL, then turns off.
- R7: A read strobe while the store is empty does nothing, and the outputs keep their values.
- R8: While enable is low, the scan column returns to 0 and both outputs read 0 from the next clock on. No entry is queued or read, and queued entries are kept.
- R9: Reset (`rstN` low) empties the store, zeroes the pointers, the tally, the throttle and the scan column, and drives both outputs to 0.
- R10: Between accepted reads, `location` and `lookupEn` hold their last values while enable stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Scan and drain enable |
| readStrobe | input | 1 | Single-cycle request to pop one entry |
| rowBits | input | COLS (8) | Image row, bit k is column k |
| location | output | log2(COLS) (3) | Column index of the last entry read |
| lookupEn | output | 1 | Status bit of the last entry read |

## Verification
The assertions check the occupancy arithmetic on every cycle, along with the high-water cap, the absence of queueing and scan movement under throttle, the throttle's entry and its release exactly when the hold timer expires, the refusal to read from an empty store, and the cleared outputs after enable goes low. The order of entries, the exact column values that come out, the outputs holding between reads and the contents surviving a disable can only be shown by the bench's scenarios. The bench compares every cycle of a dense random run, and a few directed row patterns, against its own cycle model of the lane.

// File: rtl/rowscan_pkg.sv
package rowscan_pkg;

  // Strobes issued by the control to the datapath each cycle.
  typedef struct packed {
    logic scanClear;    // enable low: park scan column at 0, clear outputs
    logic scanAdvance;  // step the scan column
    logic pushEn;       // queue the current package
    logic popEn;        // read the oldest entry to the outputs
  } laneStrb_t;

endpackage

// File: rtl/rowscan_ctrl.sv
module rowscan_ctrl
  import rowscan_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 14,
  parameter int HOLD     = 9,
  localparam int TW      = $clog2(DEPTH + 1),
  localparam int HW      = $clog2(HOLD + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          readStrobe,
  input  logic          statusBit,
  output laneStrb_t     strb,
  output logic [TW-1:0] tallyQ,
  output logic          afQ,
  output logic [HW-1:0] timerQ
);

  logic [TW-1:0] tallyNext;
  logic          emptyNow;

  assign emptyNow = (tallyQ == '0);

  always_comb begin
    strb.scanClear   = !enable;
    strb.scanAdvance = enable && !afQ;
    strb.pushEn      = enable && statusBit && !afQ;
    strb.popEn       = enable && readStrobe && !emptyNow;
  end

  always_comb begin
    tallyNext = tallyQ;
    if (strb.pushEn && !strb.popEn) tallyNext = tallyQ + TW'(1);
    else if (!strb.pushEn && strb.popEn) tallyNext = tallyQ - TW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tallyQ <= '0;
      afQ    <= 1'b0;
      timerQ <= '0;
    end else begin
      tallyQ <= tallyNext;
      if (tallyNext == TW'(AF_LEVEL)) begin
        afQ    <= 1'b1;
        timerQ <= HW'(1);
      end else if (timerQ != '0 && timerQ < HW'(HOLD)) begin
        afQ    <= 1'b1;
        timerQ <= timerQ + HW'(1);
      end else begin
        afQ    <= 1'b0;
        timerQ <= '0;
      end
    end
  end

endmodule

// File: rtl/rowscan_dp.sv
module rowscan_dp
  import rowscan_pkg::*;
#(
  parameter int COLS  = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(COLS),
  localparam int PW   = $clog2(DEPTH),
  localparam int EW   = CW + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [COLS-1:0] rowBits,
  input  laneStrb_t       strb,
  output logic            statusBit,
  output logic [CW-1:0]   scanCount,
  output logic [CW-1:0]   location,
  output logic            lookupEn
);

  logic [EW-1:0] store [DEPTH];
  logic [PW-1:0] wrPtr;
  logic [PW-1:0] rdPtr;
  logic [EW-1:0] package_w;
  logic [EW-1:0] headEntry;

  assign statusBit = rowBits[scanCount];
  assign package_w = {statusBit, scanCount};
  assign headEntry = store[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanCount <= '0;
    end else if (strb.scanClear) begin
      scanCount <= '0;
    end else if (strb.scanAdvance) begin
      scanCount <= (scanCount == CW'(COLS - 1)) ? '0 : scanCount + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.pushEn) store[wrPtr] <= package_w;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.pushEn) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + PW'(1);
      if (strb.popEn)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      location <= '0;
      lookupEn <= 1'b0;
    end else if (strb.scanClear) begin
      location <= '0;
      lookupEn <= 1'b0;
    end else if (strb.popEn) begin
      location <= headEntry[CW-1:0];
      lookupEn <= headEntry[EW-1];
    end
  end

endmodule

// File: rtl/rowscan_lane.sv
module rowscan_lane
  import rowscan_pkg::*;
#(
  parameter int COLS     = 8,
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 14,
  parameter int HOLD     = 9,
  localparam int CW      = $clog2(COLS),
  localparam int TW      = $clog2(DEPTH + 1),
  localparam int HW      = $clog2(HOLD + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic            readStrobe,
  input  logic [COLS-1:0] rowBits,
  output logic [CW-1:0]   location,
  output logic            lookupEn
);

  laneStrb_t     strb;
  logic          statusBit;
  logic [CW-1:0] scanCount;
  logic [TW-1:0] tallyQ;
  logic          afQ;
  logic [HW-1:0] timerQ;

  rowscan_ctrl #(.DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .HOLD(HOLD)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .readStrobe(readStrobe),
    .statusBit(statusBit), .strb(strb), .tallyQ(tallyQ), .afQ(afQ),
    .timerQ(timerQ)
  );

  rowscan_dp #(.COLS(COLS), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .rowBits(rowBits), .strb(strb),
    .statusBit(statusBit), .scanCount(scanCount), .location(location),
    .lookupEn(lookupEn)
  );

endmodule

// File: rtl/rowscan_lane_chk.sv
module rowscan_lane_chk
  import rowscan_pkg::*;
#(
  parameter int COLS     = 8,
  parameter int DEPTH    = 16,
  parameter int AF_LEVEL = 14,
  parameter int HOLD     = 9,
  localparam int CW      = $clog2(COLS),
  localparam int TW      = $clog2(DEPTH + 1),
  localparam int HW      = $clog2(HOLD + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          enable,
  input laneStrb_t     strb,
  input logic [CW-1:0] scanCount,
  input logic [CW-1:0] location,
  input logic          lookupEn,
  input logic [TW-1:0] tallyQ,
  input logic          afQ,
  input logic [HW-1:0] timerQ
);

  logic pastValid;
  logic pushW;
  logic popW;

  assign pushW = strb.pushEn;
  assign popW  = strb.popEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  AST_TALLY_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |-> tallyQ == $past(tallyQ) + TW'($past(pushW)) - TW'($past(popW))); // R5
  AST_TALLY_CAP: assert property (@(posedge clk) disable iff (!rstN)
    tallyQ <= TW'(AF_LEVEL)); // R5
  AST_NO_PUSH_THROTTLED: assert property (@(posedge clk) disable iff (!rstN)
    afQ |-> !pushW); // R3
  AST_SCAN_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(enable) && $past(afQ)) |-> $stable(scanCount)); // R3
  AST_THROTTLE_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(tallyQ) != TW'(AF_LEVEL) && tallyQ == TW'(AF_LEVEL)) |=> afQ); // R6
  AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(afQ) |-> $past(timerQ) == HW'(HOLD)); // R6
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (tallyQ == '0) |-> !popW); // R7
  AST_DISABLED_OUT: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(enable)) |-> (location == '0 && !lookupEn && scanCount == '0)); // R8

endmodule

bind rowscan_lane rowscan_lane_chk #(
  .COLS(COLS), .DEPTH(DEPTH), .AF_LEVEL(AF_LEVEL), .HOLD(HOLD)
) i_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .strb(strb),
  .scanCount(scanCount), .location(location), .lookupEn(lookupEn),
  .tallyQ(tallyQ), .afQ(afQ), .timerQ(timerQ)
);

// File: tb/test_rowscan_lane.sv
`timescale 1ns/1ps
module test_rowscan_lane;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       readStrobe = 1'b0;
  logic [7:0] rowBits = '0;
  logic [2:0] location;
  logic       lookupEn;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Cycle model of the lane, built from the requirements.
  logic [2:0] mMem [16];
  int mWr, mRd, mTally, mTimer, mScan;
  bit mAf;
  logic [2:0] mLoc;
  logic mLe;

  always #5 clk = ~clk;

  rowscan_lane i_rowscan_lane (
    .clk(clk), .rstN(rstN), .enable(enable), .readStrobe(readStrobe),
    .rowBits(rowBits), .location(location), .lookupEn(lookupEn)
  );

  function automatic int nextTally(int t, bit w, bit r);
    return t + (w ? 1 : 0) - (r ? 1 : 0);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWr = 0; mRd = 0; mTally = 0; mTimer = 0; mScan = 0; mAf = 0;
      mLoc = '0; mLe = 1'b0;
    end else begin
      bit st, w, r;
      int tn;
      st = rowBits[mScan];
      w  = enable && st && !mAf;
      r  = enable && readStrobe && (mTally != 0);
      if (!enable) begin mLoc = '0; mLe = 1'b0; end
      else if (r) begin mLoc = mMem[mRd]; mLe = 1'b1; end
      if (w) begin mMem[mWr] = 3'(mScan); mWr = (mWr + 1) % 16; end
      if (r) mRd = (mRd + 1) % 16;
      tn = nextTally(mTally, w, r);
      if (!enable) mScan = 0;
      else if (!mAf) mScan = (mScan + 1) % 8;
      if (tn == 14) begin mAf = 1; mTimer = 1; end
      else if (mTimer != 0 && mTimer < 9) begin mAf = 1; mTimer++; end
      else begin mAf = 0; mTimer = 0; end
      mTally = tn;
    end
  end

  task automatic expectOut(string req, logic [2:0] eLoc, logic eLe);
    checks++;
    if (location !== eLoc || lookupEn !== eLe) begin
      errors++;
      $display("FAIL %s: location=%0d lookupEn=%0d expected location=%0d lookupEn=%0d",
               req, location, lookupEn, eLoc, eLe);
    end
  endtask

  // Drive at negedge, let one edge pass, compare with the model at the next negedge.
  task automatic step(string req, logic [7:0] row, logic en, logic rs);
    rowBits = row; enable = en; readStrobe = rs;
    @(posedge clk);
    @(negedge clk);
    expectOut(req, mLoc, mLe);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    expectOut("R9 reset", 3'd0, 1'b0);
    rstN = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    doReset();

    // R2 R4 R7 R10: sparse row, pixels at columns 2 and 5 only.
    for (int i = 0; i < 8; i++) step("R1 R2 scan", 8'h24, 1'b1, 1'b0);
    step("R10 hold", 8'h00, 1'b1, 1'b0);
    expectOut("R10 no read yet", 3'd0, 1'b0);
    step("R4 read1", 8'h00, 1'b1, 1'b1);
    expectOut("R4 first entry", 3'd2, 1'b1);
    step("R4 read2", 8'h00, 1'b1, 1'b1);
    expectOut("R4 second entry", 3'd5, 1'b1);
    step("R7 empty read", 8'h00, 1'b1, 1'b1);
    expectOut("R7 empty strobe ignored", 3'd5, 1'b1);
    step("R10 idle", 8'h00, 1'b1, 1'b0);
    expectOut("R10 hold value", 3'd5, 1'b1);

    // R8: disable clears outputs but keeps queued entries.
    for (int i = 0; i < 8; i++) step("R2 queue", 8'h80, 1'b1, 1'b0);
    step("R8 disable", 8'h00, 1'b0, 1'b1);
    expectOut("R8 outputs cleared", 3'd0, 1'b0);
    step("R8 disabled", 8'h00, 1'b0, 1'b1);
    step("R8 reenable read", 8'h00, 1'b1, 1'b1);
    expectOut("R8 entry kept", 3'd7, 1'b1);

    // R3 R5 R6: dense row, no draining: fill to the high-water mark.
    for (int i = 0; i < 40; i++) step("R3 R5 fill", 8'hFF, 1'b1, 1'b0);
    // R6: one read, then wait through the hold window while reading out.
    for (int i = 0; i < 30; i++) step("R6 throttle drain", 8'hFF, 1'b1, 1'(i % 3 == 0));
    // Drain everything with an empty row, checking order R4.
    for (int i = 0; i < 20; i++) step("R4 R7 drain", 8'h00, 1'b1, 1'b1);

    // R9: reset in the middle of traffic.
    for (int i = 0; i < 10; i++) step("R2 prefill", 8'h5A, 1'b1, 1'b0);
    doReset();
    step("R9 empty after reset", 8'h00, 1'b1, 1'b1);
    expectOut("R9 nothing left", 3'd0, 1'b0);

    // Random traffic: mostly dense rows, slow drain, occasional disable/reset.
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] row;
      logic en, rs;
      row = 8'($urandom) | 8'($urandom);
      en  = ($urandom % 20) != 0;
      rs  = ($urandom % 4) == 0;
      if ($urandom % 500 == 0) doReset();
      step("R1 R3 R4 R5 R6 R8 R10 random", row, en, rs);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule